// File: doc/BRIEF.md
# Custom Instruction Issue Controller

This block sits between a processor pipeline and a tightly coupled coprocessor that follows a two-operand, one-result model. Each cycle it looks at a 32-bit instruction word and the two register operand values the pipeline has already read. When the low opcode bits mark the word as a custom instruction, it splits the word into three register indices, three register-file select bits and an 8-bit function code. It then hands all of these, with the operands, to the coprocessor.

In the default multi-cycle configuration the operands and fields are registered and a one-cycle start pulse is raised. The pipeline is held in a stall until the coprocessor answers with a one-cycle done. The coprocessor's clock enable follows an external stall input, so an unrelated pipeline stall freezes the coprocessor as well. In the combinational configuration the operands flow straight through, no handshake is used and the result is captured in the issue cycle. In both configurations the result and destination index come back one cycle later as a registered write-back pulse.

Top module: `ci_issue_ctrl`

## Requirements
- R1: A word is a custom instruction only when instr_valid is 1 and bits [5:0] equal 6'h32; any other word raises no start, no stall and no write-back.
- R2: Fields are decoded as: source index A from bits [31:27], source index B from [26:22], destination index C from [21:17], A-select bit 16, B-select bit 15, C-select bit 14, and function code from [13:6] (word 32'h10C5C032 gives A=2, B=3, C=2, all three selects 1, function 0).
- R3: In multi-cycle mode, the cycle after issue the operands sit on cp_dataa/cp_datab and cp_start is high. cp_start stays high until exactly one cycle in which cp_clk_en is also high, so the coprocessor samples exactly one start per instruction.
- R4: In multi-cycle mode pipe_stall is high from the issue cycle until the cycle in which cp_done is seen with cp_clk_en high, and low in that cycle. A coprocessor that raises done L enabled cycles after sampling start gives L+3 stalled cycles plus one per cycle of external stall while the instruction is in flight.
- R5: cp_clk_en is low in exactly the cycles in which ext_stall is high. An instruction is not issued in such a cycle, and a done seen while cp_clk_en is low is not taken.
- R6: One cycle after completion, wb_valid is high for exactly one cycle, with wb_data equal to the coprocessor result and wb_idx equal to C. wb_wren is high in that cycle only when the C-select bit is 1.
- R7: While an instruction is in flight, the held instruction input starts no second coprocessor operation.
- R8: With COMB_MODE=1, cp_start and pipe_stall never rise. The operands reach cp_dataa/cp_datab in the issue cycle, and wb_valid pulses the next cycle with the coprocessor result.
- R9: Synchronous active-high reset leaves cp_start, pipe_stall, wb_valid and wb_wren low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word, held until the stall releases |
| opa | input | 32 | First register operand value |
| opb | input | 32 | Second register operand value |
| ext_stall | input | 1 | Pipeline stall from an unrelated source |
| cp_dataa | output | 32 | First operand to the coprocessor |
| cp_datab | output | 32 | Second operand to the coprocessor |
| cp_n | output | 8 | Function code to the coprocessor |
| cp_a | output | 5 | Source index A |
| cp_b | output | 5 | Source index B |
| cp_c | output | 5 | Destination index C |
| cp_readra | output | 1 | A refers to the processor register file |
| cp_readrb | output | 1 | B refers to the processor register file |
| cp_writerc | output | 1 | C refers to the processor register file |
| cp_start | output | 1 | Start of a multi-cycle operation |
| cp_clk_en | output | 1 | Clock enable for the coprocessor's registers |
| cp_result | input | 32 | Coprocessor result |
| cp_done | input | 1 | Coprocessor completion pulse |
| pipe_stall | output | 1 | Holds the pipeline while an instruction is in flight |
| wb_valid | output | 1 | Write-back pulse |
| wb_data | output | 32 | Result to write back |
| wb_idx | output | 5 | Destination index for write-back |
| wb_wren | output | 1 | Register-file write request |

## Verification
A wrong busy state shows at the ports within one cycle. A controller that forgets it is busy pulses start a second time while the instruction is held. One that never leaves busy keeps pipe_stall high through the done cycle, so the stall count the bench measures for each latency is off by at least one. A wrong field latch or operand register shows as a bad wb_idx, wb_wren or wb_data in the single write-back cycle, which the bench checks across a sweep of field patterns and coprocessor latencies. A clock-enable fault shows in the first externally stalled cycle, as cp_clk_en high or as an early completion.

// File: rtl/ci_pkg.sv
package ci_pkg;

    localparam int XLEN      = 32;
    localparam int IDXW      = 5;
    localparam int FNW       = 8;
    localparam int OPW       = 6;
    localparam logic [OPW-1:0] CI_OPCODE = 6'h32;

    // Packed in instruction bit order: index A sits at the top, opcode at the bottom.
    typedef struct packed {
        logic [IDXW-1:0] idx_a;
        logic [IDXW-1:0] idx_b;
        logic [IDXW-1:0] idx_c;
        logic            sel_a;
        logic            sel_b;
        logic            sel_c;
        logic [FNW-1:0]  func;
        logic [OPW-1:0]  opcode;
    } ci_word_t;

    // Everything the coprocessor sees for one operation.
    typedef struct packed {
        logic [XLEN-1:0] dataa;
        logic [XLEN-1:0] datab;
        logic [IDXW-1:0] idx_a;
        logic [IDXW-1:0] idx_b;
        logic [IDXW-1:0] idx_c;
        logic            sel_a;
        logic            sel_b;
        logic            sel_c;
        logic [FNW-1:0]  func;
    } ci_issue_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_BUSY = 1'b1
    } ci_seq_state_t;

    function automatic logic is_custom(input ci_word_t w);
        return w.opcode == CI_OPCODE;
    endfunction

    function automatic ci_issue_t build_issue(input ci_word_t w,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
        ci_issue_t r;
        r.dataa = a;
        r.datab = b;
        r.idx_a = w.idx_a;
        r.idx_b = w.idx_b;
        r.idx_c = w.idx_c;
        r.sel_a = w.sel_a;
        r.sel_b = w.sel_b;
        r.sel_c = w.sel_c;
        r.func  = w.func;
        return r;
    endfunction

endpackage

// File: rtl/ci_decoder.sv
module ci_decoder
    import ci_pkg::*;
(
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr_word,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    output logic            hit,
    output ci_issue_t       issue
);
    ci_word_t w;

    always_comb begin
        w     = ci_word_t'(instr_word);
        hit   = instr_valid && is_custom(w);
        issue = build_issue(w, opa, opb);
    end
endmodule

// File: rtl/ci_seq.sv
module ci_seq
    import ci_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic issue_req,
    input  logic clk_en,
    input  logic done,
    output logic accept,
    output logic complete,
    output logic start,
    output logic stall
);
    ci_seq_state_t state_q;

    always_comb begin
        accept   = (state_q == SEQ_IDLE) && issue_req;
        complete = (state_q == SEQ_BUSY) && done && clk_en;
        stall    = accept || ((state_q == SEQ_BUSY) && !complete);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            start   <= 1'b0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        state_q <= SEQ_BUSY;
                        start   <= 1'b1;
                    end
                end
                SEQ_BUSY: begin
                    // Start is held until the coprocessor is enabled to sample it.
                    if (start && clk_en) start <= 1'b0;
                    if (complete) state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ci_wb.sv
module ci_wb
    import ci_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            complete,
    input  logic [XLEN-1:0] result,
    input  logic [IDXW-1:0] idx_c,
    input  logic            sel_c,
    output logic            wb_valid,
    output logic [XLEN-1:0] wb_data,
    output logic [IDXW-1:0] wb_idx,
    output logic            wb_wren
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_wren  <= 1'b0;
            wb_data  <= '0;
            wb_idx   <= '0;
        end else begin
            wb_valid <= complete;
            wb_wren  <= complete && sel_c;
            if (complete) begin
                wb_data <= result;
                wb_idx  <= idx_c;
            end
        end
    end
endmodule

// File: rtl/ci_issue_ctrl.sv
module ci_issue_ctrl
    import ci_pkg::*;
#(
    parameter bit COMB_MODE = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            instr_valid,
    input  logic [XLEN-1:0] instr_word,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            ext_stall,
    output logic [XLEN-1:0] cp_dataa,
    output logic [XLEN-1:0] cp_datab,
    output logic [FNW-1:0]  cp_n,
    output logic [IDXW-1:0] cp_a,
    output logic [IDXW-1:0] cp_b,
    output logic [IDXW-1:0] cp_c,
    output logic            cp_readra,
    output logic            cp_readrb,
    output logic            cp_writerc,
    output logic            cp_start,
    output logic            cp_clk_en,
    input  logic [XLEN-1:0] cp_result,
    input  logic            cp_done,
    output logic            pipe_stall,
    output logic            wb_valid,
    output logic [XLEN-1:0] wb_data,
    output logic [IDXW-1:0] wb_idx,
    output logic            wb_wren
);
    logic      hit;
    logic      issue_req;
    logic      complete;
    ci_issue_t iss_d;
    ci_issue_t iss_cur;

    ci_decoder u_dec (
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .opa         (opa),
        .opb         (opb),
        .hit         (hit),
        .issue       (iss_d)
    );

    assign cp_clk_en = !ext_stall;
    assign issue_req = hit && !ext_stall;

    generate
        if (COMB_MODE) begin : g_comb
            logic unused_comb_done;
            assign unused_comb_done = cp_done;
            assign iss_cur    = iss_d;
            assign cp_start   = 1'b0;
            assign pipe_stall = 1'b0;
            assign complete   = issue_req;
        end else begin : g_multi
            logic      accept;
            ci_issue_t iss_q;

            ci_seq u_seq (
                .clk       (clk),
                .rst       (rst),
                .issue_req (issue_req),
                .clk_en    (cp_clk_en),
                .done      (cp_done),
                .accept    (accept),
                .complete  (complete),
                .start     (cp_start),
                .stall     (pipe_stall)
            );

            always_ff @(posedge clk) begin
                if (rst) iss_q <= '0;
                else if (accept) iss_q <= iss_d;
            end

            assign iss_cur = iss_q;
        end
    endgenerate

    assign cp_dataa   = iss_cur.dataa;
    assign cp_datab   = iss_cur.datab;
    assign cp_n       = iss_cur.func;
    assign cp_a       = iss_cur.idx_a;
    assign cp_b       = iss_cur.idx_b;
    assign cp_c       = iss_cur.idx_c;
    assign cp_readra  = iss_cur.sel_a;
    assign cp_readrb  = iss_cur.sel_b;
    assign cp_writerc = iss_cur.sel_c;

    ci_wb u_wb (
        .clk      (clk),
        .rst      (rst),
        .complete (complete),
        .result   (cp_result),
        .idx_c    (iss_cur.idx_c),
        .sel_c    (iss_cur.sel_c),
        .wb_valid (wb_valid),
        .wb_data  (wb_data),
        .wb_idx   (wb_idx),
        .wb_wren  (wb_wren)
    );
endmodule

// File: rtl/ci_issue_chk.sv
module ci_issue_chk #(
    parameter bit COMB_MODE = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr_word,
    input logic        ext_stall,
    input logic        cp_start,
    input logic        cp_clk_en,
    input logic        cp_done,
    input logic [4:0]  cp_c,
    input logic        pipe_stall,
    input logic        wb_valid,
    input logic        wb_wren
);
    AST_START_CUSTOM: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_start) |-> $past(instr_valid && instr_word[5:0] == 6'h32)); // R1
    AST_DEST_FIELD: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_start) |-> cp_c == $past(instr_word[21:17])); // R2
    AST_START_ONCE: assert property (@(posedge clk) disable iff (rst)
        cp_start && cp_clk_en |=> !cp_start); // R3
    AST_START_STALLS: assert property (@(posedge clk) disable iff (rst)
        cp_start |-> pipe_stall); // R4
    AST_NO_ISSUE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        $rose(cp_start) |-> !$past(ext_stall)); // R5
    AST_WB_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        wb_valid && !COMB_MODE |-> $past(cp_done && cp_clk_en)); // R6
    AST_WB_PULSE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> !wb_valid); // R6
    AST_WREN_QUAL: assert property (@(posedge clk) disable iff (rst)
        wb_wren |-> wb_valid); // R6
    AST_COMB_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        pipe_stall || cp_start |-> !COMB_MODE); // R8
endmodule

bind ci_issue_ctrl ci_issue_chk #(.COMB_MODE(COMB_MODE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .ext_stall   (ext_stall),
    .cp_start    (cp_start),
    .cp_clk_en   (cp_clk_en),
    .cp_done     (cp_done),
    .cp_c        (cp_c),
    .pipe_stall  (pipe_stall),
    .wb_valid    (wb_valid),
    .wb_wren     (wb_wren)
);

// File: tb/test_ci_issue_ctrl.sv
`timescale 1ns/1ps
module test_ci_issue_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic        valid_c = 1'b0;
    logic [31:0] instr_word = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        ext_stall = 1'b0;

    // multi-cycle instance signals
    logic [31:0] m_dataa, m_datab, m_result, m_wb_data;
    logic [7:0]  m_n;
    logic [4:0]  m_a, m_b, m_c, m_wb_idx;
    logic        m_ra, m_rb, m_wc, m_start, m_clk_en, m_done, m_stall, m_wb_valid, m_wb_wren;
    // combinational instance signals
    logic [31:0] c_dataa, c_datab, c_result, c_wb_data;
    logic [7:0]  c_n;
    logic [4:0]  c_a, c_b, c_c, c_wb_idx;
    logic        c_ra, c_rb, c_wc, c_start, c_clk_en, c_stall, c_wb_valid, c_wb_wren;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int starts = 0;
    int wb_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ci_issue_ctrl #(.COMB_MODE(1'b0)) i_ci_issue_ctrl (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .opa(opa), .opb(opb), .ext_stall(ext_stall),
        .cp_dataa(m_dataa), .cp_datab(m_datab), .cp_n(m_n), .cp_a(m_a), .cp_b(m_b),
        .cp_c(m_c), .cp_readra(m_ra), .cp_readrb(m_rb), .cp_writerc(m_wc),
        .cp_start(m_start), .cp_clk_en(m_clk_en), .cp_result(m_result), .cp_done(m_done),
        .pipe_stall(m_stall), .wb_valid(m_wb_valid), .wb_data(m_wb_data),
        .wb_idx(m_wb_idx), .wb_wren(m_wb_wren)
    );

    ci_issue_ctrl #(.COMB_MODE(1'b1)) i_ci_issue_ctrl_comb (
        .clk(clk), .rst(rst), .instr_valid(valid_c), .instr_word(instr_word),
        .opa(opa), .opb(opb), .ext_stall(ext_stall),
        .cp_dataa(c_dataa), .cp_datab(c_datab), .cp_n(c_n), .cp_a(c_a), .cp_b(c_b),
        .cp_c(c_c), .cp_readra(c_ra), .cp_readrb(c_rb), .cp_writerc(c_wc),
        .cp_start(c_start), .cp_clk_en(c_clk_en), .cp_result(c_result), .cp_done(1'b0),
        .pipe_stall(c_stall), .wb_valid(c_wb_valid), .wb_data(c_wb_data),
        .wb_idx(c_wb_idx), .wb_wren(c_wb_wren)
    );

    function automatic logic [31:0] cp_fn(input logic [31:0] a, input logic [31:0] b,
                                          input logic [7:0] n);
        return (a + b) ^ {4{n}};
    endfunction

    function automatic logic [31:0] mk_word(input int a, input int b, input int c,
                                            input bit ra, input bit rb, input bit wc,
                                            input int n, input int op);
        return (32'(a) << 27) | (32'(b) << 22) | (32'(c) << 17) | (32'(ra) << 16)
             | (32'(rb) << 15) | (32'(wc) << 14) | (32'(n & 255) << 6) | 32'(op & 63);
    endfunction

    // Behavioural coprocessor: done L enabled cycles after sampling start; frozen when clk_en is low.
    logic [31:0] cop_res = '0;
    logic        cop_pend = 1'b0;
    int          cop_cnt = 0;
    assign m_result = cop_res;
    assign c_result = cp_fn(c_dataa, c_datab, c_n);

    always @(posedge clk) begin
        if (rst) begin
            cop_pend <= 1'b0;
            m_done   <= 1'b0;
            cop_cnt  <= 0;
        end else if (m_clk_en) begin
            m_done <= 1'b0;
            if (m_start && !cop_pend) begin
                starts   <= starts + 1;
                cop_res  <= cp_fn(m_dataa, m_datab, m_n);
                cop_cnt  <= lat;
                cop_pend <= 1'b1;
            end else if (cop_pend) begin
                if (cop_cnt == 0) begin
                    m_done   <= 1'b1;
                    cop_pend <= 1'b0;
                end else begin
                    cop_cnt <= cop_cnt - 1;
                end
            end
        end
        if (!rst && (m_wb_valid || c_wb_valid)) wb_seen <= wb_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_multi(input logic [31:0] word, input logic [31:0] a,
                             input logic [31:0] b, input int lat_i,
                             input int ext_at, input int ext_len);
        int n;
        int s0;
        logic [31:0] exp_res;
        exp_res = cp_fn(a, b, word[13:6]);
        lat = lat_i;
        @(negedge clk);
        instr_word = word; opa = a; opb = b; instr_valid = 1'b1; ext_stall = 1'b0;
        s0 = starts;
        n = 0;
        #1;
        while (m_stall && n < 1000) begin
            n++;
            @(negedge clk);
            if (ext_len > 0 && n == ext_at) ext_stall = 1'b1;
            if (ext_len > 0 && n == ext_at + ext_len) ext_stall = 1'b0;
            #1;
            if (ext_stall) chk(m_clk_en == 1'b0, "R5 clk_en low in ext stall", 32'(m_clk_en), 0);
            if (n == 1) begin
                chk(m_start == 1'b1, "R3 start after issue", 32'(m_start), 1);
                chk(m_dataa == a && m_datab == b, "R3 operands", m_dataa, a);
                chk(m_a == word[31:27] && m_b == word[26:22] && m_c == word[21:17],
                    "R2 indices", {m_a, m_b, m_c}, {word[31:27], word[26:22], word[21:17]});
                chk({m_ra, m_rb, m_wc} == word[16:14] && m_n == word[13:6],
                    "R2 selects and function", {m_ra, m_rb, m_wc, m_n},
                    {word[16:14], word[13:6]});
            end
        end
        instr_valid = 1'b0;
        chk(n == lat_i + 3 + ext_len, "R4 stall length", n, lat_i + 3 + ext_len);
        @(negedge clk); #1;
        chk(m_wb_valid == 1'b1, "R6 wb_valid", 32'(m_wb_valid), 1);
        chk(m_wb_data == exp_res, "R6 wb_data", m_wb_data, exp_res);
        chk(m_wb_idx == word[21:17], "R6 wb_idx", m_wb_idx, word[21:17]);
        chk(m_wb_wren == word[14], "R6 wb_wren follows C-select", 32'(m_wb_wren), word[14]);
        chk(starts - s0 == 1, "R7 one start per instruction", starts - s0, 1);
        @(negedge clk); #1;
        chk(m_wb_valid == 1'b0 && m_wb_wren == 1'b0, "R6 single-cycle pulse",
            32'(m_wb_valid), 0);
    endtask

    task automatic run_comb(input logic [31:0] word, input logic [31:0] a,
                            input logic [31:0] b);
        logic [31:0] exp_res;
        exp_res = cp_fn(a, b, word[13:6]);
        @(negedge clk);
        instr_word = word; opa = a; opb = b; valid_c = 1'b1;
        #1;
        chk(c_stall == 1'b0 && c_start == 1'b0, "R8 no stall no start", {c_stall, c_start}, 0);
        chk(c_dataa == a && c_datab == b, "R8 operands pass through", c_dataa, a);
        @(negedge clk);
        valid_c = 1'b0;
        #1;
        chk(c_wb_valid == 1'b1 && c_wb_data == exp_res, "R8 result next cycle", c_wb_data, exp_res);
        chk(c_wb_idx == word[21:17] && c_wb_wren == word[14], "R8 index and write enable",
            {c_wb_idx, c_wb_wren}, {word[21:17], word[14]});
        @(negedge clk); #1;
        chk(c_wb_valid == 1'b0, "R8 single pulse", 32'(c_wb_valid), 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!m_start && !m_stall && !m_wb_valid && !m_wb_wren, "R9 reset state",
            {m_start, m_stall, m_wb_valid, m_wb_wren}, 0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!m_start && !m_stall && !c_stall, "R9 after reset release",
            {m_start, m_stall, c_stall}, 0);

        // R2: the reference word
        run_multi(32'h10C5C032, 32'hFFFF_FFFE, 32'd3, 1, 0, 0);
        chk(m_a == 5'd2 && m_b == 5'd3 && m_c == 5'd2, "R2 word 10C5C032 indices",
            {m_a, m_b, m_c}, {5'd2, 5'd3, 5'd2});
        chk(m_ra && m_rb && m_wc && m_n == 8'd0, "R2 word 10C5C032 selects",
            {m_ra, m_rb, m_wc, m_n}, {3'b111, 8'd0});

        // Sweep of field patterns against coprocessor latencies 0..5
        for (int i = 0; i < 24; i++) begin
            run_multi(mk_word((i * 7) % 32, (i * 5 + 3) % 32, (i * 11 + 1) % 32,
                              i[0], i[1], (i % 3) != 0, i * 21 + 1, 6'h32),
                      32'h1357_0000 + 32'(i * 977), 32'hA5A5_0F0F ^ 32'(i << 9), i % 6, 0, 0);
        end

        // R5: external stalls of several lengths while in flight
        for (int k = 1; k <= 4; k++) begin
            run_multi(mk_word(k, k + 1, k + 9, 1'b1, 1'b0, 1'b1, 8'h40 + k, 6'h32),
                      32'(k * 1000), 32'(-k), 3, 2, k);
        end

        // R5: no issue while ext_stall is high
        @(negedge clk);
        instr_word = mk_word(1, 2, 3, 1'b1, 1'b1, 1'b1, 5, 6'h32);
        instr_valid = 1'b1; ext_stall = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(m_start == 1'b0 && m_clk_en == 1'b0, "R5 no issue when frozen",
                {m_start, m_clk_en}, 0);
        end
        instr_valid = 1'b0; ext_stall = 1'b0;
        @(negedge clk); #1;
        chk(m_wb_valid == 1'b0, "R5 no write-back when frozen", 32'(m_wb_valid), 0);

        // R1: other opcodes and an invalid custom word do nothing
        wb_seen = 0;
        for (int op = 0; op < 64; op += 5) begin
            if (op == 'h32) continue;
            @(negedge clk);
            instr_word = mk_word(op % 32, 4, 7, 1'b1, 1'b1, 1'b1, op, op);
            instr_valid = 1'b1; valid_c = 1'b1;
            #1;
            chk(!m_stall && !c_stall, "R1 no stall on other opcode", {m_stall, c_stall}, 0);
            @(negedge clk); #1;
            chk(!m_start, "R1 no start on other opcode", 32'(m_start), 0);
        end
        @(negedge clk);
        instr_word = mk_word(3, 4, 5, 1'b1, 1'b1, 1'b1, 9, 6'h32);
        instr_valid = 1'b0; valid_c = 1'b0;
        @(negedge clk); #1;
        chk(!m_start && !m_stall, "R1 invalid custom word ignored", {m_start, m_stall}, 0);
        @(negedge clk); #1;
        chk(wb_seen == 0, "R1 no write-back", wb_seen, 0);

        // R8: combinational instance
        for (int i = 0; i < 12; i++) begin
            run_comb(mk_word((i * 3) % 32, i, 31 - i, i[1], i[0], i[0] ^ i[1], i * 19, 6'h32),
                     32'h0F0F_0000 + 32'(i * 4099), 32'(i * 65537));
        end
        @(negedge clk);
        instr_word = mk_word(1, 1, 9, 1'b1, 1'b1, 1'b1, 2, 6'h32);
        valid_c = 1'b1; ext_stall = 1'b1;
        @(negedge clk);
        valid_c = 1'b0; ext_stall = 1'b0;
        #1;
        chk(c_wb_valid == 1'b0, "R5 comb no capture when frozen", 32'(c_wb_valid), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule